// File: doc/BRIEF.md
# Clocked Programmable Tap Delay Line

This block replays a one-bit input stream on its output after a delay picked by a small select code. The delay counts whole clock cycles and grows in equal steps with the code: a fixed base delay plus one step increment for each unit of the code. Every input bit enters a shift chain that is cleared at reset. The output is taken from one tap of that chain, and the tap follows the select code in the same cycle. A force-low input drives the output low at once, while the chain keeps shifting underneath.

Because the select code is not captured, changing it while data is in flight can expose bits that were already shifted. The block therefore watches two timing rules and raises a sticky flag for each one that is broken. The first rule sets how long the output must stay quiet before the code may be raised. The second sets how long a force-low episode must last, with the input held low, before it ends. Both flags are advisory and never change the data path.

Top module: `prog_tap_delay`

## Requirements
- R1: While rst_n is low, data_out, early_sel_err and short_hold_err are 0. After release the chain holds only zeros, so data_out stays 0 until input bits reach the selected tap.
- R2: With force_low low and a constant sel_code s, a bit sampled on data_in at clock edge n appears on data_out during the cycle after edge n+D-1, where D = BASE_DLY + STEP_DLY*s and sel_code is read as an unsigned number.
- R3: The select code is not latched. A change on sel_code moves data_out to the new tap within the same cycle, with no clock edge in between.
- R4: While force_low is 1, data_out is 0 in that same cycle. The chain keeps shifting, so bits sampled while forced appear on data_out after release at their normal delay.
- R5: When sel_code is higher at a clock edge than at the previous edge by k, and fewer than k*STEP_DLY edges have passed since the last edge at which data_out had changed value, early_sel_err is set. Exactly k*STEP_DLY quiet edges is legal.
- R6: Lowering sel_code, or keeping it unchanged, never sets early_sel_err.
- R7: A force-low episode ends at the first edge that samples force_low at 0 after an edge that sampled it at 1. If fewer than sel_code*STEP_DLY consecutive forced edges with data_in at 0 came right before that end, short_hold_err is set. Exactly sel_code*STEP_DLY such edges is legal.
- R8: A forced edge that samples data_in at 1 restarts the hold count at zero. With sel_code at 0 the required hold is zero cycles.
- R9: Both flags stay at 1 until reset. They have no effect on data_out.
- R10: The quiet-time count starts out saturated after reset, so the first code change after reset never sets early_sel_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Serial data to be delayed |
| sel_code | input | SEL_W | Delay step select, unsigned |
| force_low | input | 1 | 1 forces data_out low |
| data_out | output | 1 | Delayed data |
| early_sel_err | output | 1 | Sticky flag: select code raised too soon |
| short_hold_err | output | 1 | Sticky flag: force-low episode too short |

## Verification
The bench builds the block with SEL_W=3, BASE_DLY=2 and STEP_DLY=3. That gives a 23-stage chain and required waits of up to 21 cycles, short enough to probe every tap and both timing rules at their exact boundaries within a few hundred cycles. Because the step is 3 and not 1, a design that drops or misplaces the step multiplication gives wrong tap positions and wrong wait thresholds. A long random phase then mixes code changes and force-low episodes, and a behavioural queue model checks the output and both flags on every cycle.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

   // Number of cycles a rule demands for a code difference of diff steps.
   function automatic int unsigned pdl_wait_cycles(input int unsigned diff,
                                                   input int unsigned step);
      return diff * step;
   endfunction

   // Longest chain needed for a given select width and delay pair.
   function automatic int unsigned pdl_chain_len(input int unsigned sel_w,
                                                 input int unsigned base,
                                                 input int unsigned step);
      return base + ((1 << sel_w) - 1) * step;
   endfunction

endpackage

// File: rtl/pdl_shift_chain.sv
module pdl_shift_chain #(
   parameter int unsigned DEPTH = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   output logic [DEPTH-1:0] stages
);

   initial begin
      if (DEPTH < 1) $fatal(1, "pdl_shift_chain: DEPTH must be at least 1");
   end

   // Stage 0 samples the input; each later stage copies its neighbour.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages[0] <= 1'b0;
      else        stages[0] <= bit_in;
   end

   generate
      for (genvar k = 1; k < DEPTH; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stages[k] <= 1'b0;
            else        stages[k] <= stages[k-1];
         end
      end
   endgenerate

endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_DLY = 2,
   parameter int unsigned STEP_DLY = 3,
   parameter int unsigned DEPTH    = 23
) (
   input  logic [DEPTH-1:0] stages,
   input  logic [SEL_W-1:0] sel,
   input  logic             force_low,
   output logic             tap_out
);

   localparam int unsigned NTAP = 1 << SEL_W;

   logic [NTAP-1:0] taps;
   logic            picked;

   // Tap i sits at stage BASE_DLY + i*STEP_DLY - 1 (a delay of that many edges).
   generate
      for (genvar i = 0; i < NTAP; i++) begin : g_tap
         localparam int unsigned POS = BASE_DLY + i * STEP_DLY - 1;
         if (POS < DEPTH) begin : g_in_range
            assign taps[i] = stages[POS];
         end else begin : g_out_range
            assign taps[i] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      picked  = taps[sel];
      tap_out = picked & ~force_low;
   end

endmodule

// File: rtl/pdl_change_guard.sv
module pdl_change_guard #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned STEP_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             out_now,
   output logic             flag
);
   import pdl_pkg::*;

   localparam int unsigned MAX_CODE = (1 << SEL_W) - 1;
   localparam int unsigned GAP_MAX  = MAX_CODE * STEP_DLY;
   localparam int unsigned GAP_W    = $clog2(GAP_MAX + 1);

   logic [GAP_W-1:0] gap_q;
   logic [SEL_W-1:0] sel_prev_q;
   logic             out_prev_q;
   logic [GAP_W-1:0] need;
   logic             raised;
   logic             too_soon;
   logic             moved;

   always_comb begin
      raised   = sel > sel_prev_q;
      need     = GAP_W'(pdl_wait_cycles(32'(sel - sel_prev_q), STEP_DLY));
      too_soon = raised && (gap_q < need);
      moved    = out_now != out_prev_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q      <= GAP_W'(GAP_MAX);
         sel_prev_q <= '0;
         out_prev_q <= 1'b0;
         flag       <= 1'b0;
      end else begin
         sel_prev_q <= sel;
         out_prev_q <= out_now;
         if (moved)                        gap_q <= '0;
         else if (gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + 1'b1;
         if (too_soon) flag <= 1'b1;
      end
   end

endmodule

// File: rtl/pdl_hold_guard.sv
module pdl_hold_guard #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned STEP_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             force_low,
   input  logic             bit_in,
   output logic             flag
);
   import pdl_pkg::*;

   localparam int unsigned MAX_CODE = (1 << SEL_W) - 1;
   localparam int unsigned HOLD_MAX = MAX_CODE * STEP_DLY;
   localparam int unsigned HOLD_W   = $clog2(HOLD_MAX + 1);

   logic [HOLD_W-1:0] hold_q;
   logic              forced_q;
   logic [HOLD_W-1:0] need;
   logic              ending;

   always_comb begin
      need   = HOLD_W'(pdl_wait_cycles(32'(sel), STEP_DLY));
      ending = forced_q && !force_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         forced_q <= 1'b0;
         flag     <= 1'b0;
      end else begin
         forced_q <= force_low;
         if (!force_low)                    hold_q <= '0;
         else if (bit_in)                   hold_q <= '0;
         else if (hold_q != HOLD_W'(HOLD_MAX)) hold_q <= hold_q + 1'b1;
         if (ending && (hold_q < need)) flag <= 1'b1;
      end
   end

endmodule

// File: rtl/prog_tap_delay.sv
module prog_tap_delay #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_DLY = 2,
   parameter int unsigned STEP_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_in,
   input  logic [SEL_W-1:0] sel_code,
   input  logic             force_low,
   output logic             data_out,
   output logic             early_sel_err,
   output logic             short_hold_err
);
   import pdl_pkg::*;

   localparam int unsigned DEPTH = pdl_chain_len(SEL_W, BASE_DLY, STEP_DLY);

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("prog_tap_delay: SEL_W must be at least 1");
      end
      if (BASE_DLY < 1) begin : g_bad_base
         $error("prog_tap_delay: BASE_DLY must be at least 1");
      end
      if (STEP_DLY < 1) begin : g_bad_step
         $error("prog_tap_delay: STEP_DLY must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] chain;

   pdl_shift_chain #(.DEPTH(DEPTH)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (data_in),
      .stages (chain)
   );

   pdl_tap_select #(
      .SEL_W   (SEL_W),
      .BASE_DLY(BASE_DLY),
      .STEP_DLY(STEP_DLY),
      .DEPTH   (DEPTH)
   ) u_select (
      .stages   (chain),
      .sel      (sel_code),
      .force_low(force_low),
      .tap_out  (data_out)
   );

   pdl_change_guard #(.SEL_W(SEL_W), .STEP_DLY(STEP_DLY)) u_change (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel_code),
      .out_now(data_out),
      .flag   (early_sel_err)
   );

   pdl_hold_guard #(.SEL_W(SEL_W), .STEP_DLY(STEP_DLY)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel_code),
      .force_low(force_low),
      .bit_in   (data_in),
      .flag     (short_hold_err)
   );

endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
   parameter int unsigned SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             data_in,
   input logic [SEL_W-1:0] sel_code,
   input logic             force_low,
   input logic             data_out,
   input logic             early_sel_err,
   input logic             short_hold_err
);

   // R1: quiet outputs while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!data_out && !early_sel_err && !short_hold_err)
            else $error("a_r1_reset_quiet");
      end
   end

   // R4: forcing wins over the tap
   a_r4_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
      force_low |-> !data_out);

   // R9: early-change flag is sticky
   a_r9_sel_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      early_sel_err |=> early_sel_err);

   // R9: hold flag is sticky
   a_r9_hold_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      short_hold_err |=> short_hold_err);

   // R6: the early-change flag only rises after the code went up
   a_r6_rise_needs_increase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_sel_err) |-> ($past(sel_code) > $past(sel_code, 2)));

   // R7: the hold flag only rises at the end of a forced episode
   a_r7_rise_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_hold_err) |-> (!$past(force_low) && $past(force_low, 2)));

   // R8: a code of zero never demands a hold
   a_r8_zero_code_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_hold_err) |-> ($past(sel_code) != '0));

endmodule

bind prog_tap_delay pdl_checker #(.SEL_W(SEL_W)) u_pdl_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .data_in       (data_in),
   .sel_code      (sel_code),
   .force_low     (force_low),
   .data_out      (data_out),
   .early_sel_err (early_sel_err),
   .short_hold_err(short_hold_err)
);

// File: tb/prog_tap_delay_tb.sv
`timescale 1ns/1ps
module prog_tap_delay_tb;
   localparam int SEL_W   = 3;
   localparam int BASE    = 2;
   localparam int STEP    = 3;
   localparam int MAXC    = (1 << SEL_W) - 1;
   localparam int DEPTH   = BASE + MAXC * STEP;
   localparam int GAP_MAX = MAXC * STEP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0;
   logic frc = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic dout, eflag, hflag;

   always #2.5 clk = ~clk;

   prog_tap_delay #(.SEL_W(SEL_W), .BASE_DLY(BASE), .STEP_DLY(STEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .data_in(din), .sel_code(sel),
      .force_low(frc), .data_out(dout), .early_sel_err(eflag), .short_hold_err(hflag)
   );

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 0;

   // behavioural model state
   bit hist[$];
   int gap, sel_prev, hold;
   bit prev_out, frc_prev, m_e, m_h;
   bit obs;
   bit probe[0:40];

   always @(posedge clk) cycles++;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      wait (cycles > 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
      finish_run();
   end

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      hist.delete();
      for (int i = 0; i < DEPTH; i++) hist.push_back(1'b0);
      gap = GAP_MAX; sel_prev = 0; hold = 0;
      prev_out = 0; frc_prev = 0; m_e = 0; m_h = 0;
   endtask

   function automatic bit model_out(input int s, input bit f);
      int d;
      d = BASE + s * STEP;
      return f ? 1'b0 : hist[d-1];
   endfunction

   // Entered at a falling edge; leaves at the next falling edge.
   task automatic step(input bit d, input int s, input bit f, input string tag);
      bit e;
      din = d; sel = s[SEL_W-1:0]; frc = f;
      #1;
      e = model_out(s, f);
      check(tag, "data_out", dout, e);
      check(tag, "early_sel_err", eflag, m_e);
      check(tag, "short_hold_err", hflag, m_h);
      obs = dout;
      @(posedge clk);
      if (s > sel_prev && gap < (s - sel_prev) * STEP) m_e = 1;
      gap = (e != prev_out) ? 0 : ((gap < GAP_MAX) ? gap + 1 : GAP_MAX);
      prev_out = e; sel_prev = s;
      if (!f && frc_prev && hold < s * STEP) m_h = 1;
      hold = f ? (d ? 0 : ((hold < GAP_MAX) ? hold + 1 : GAP_MAX)) : 0;
      frc_prev = f;
      hist.push_front(d);
      void'(hist.pop_back());
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 0; din = 0; frc = 0;
      repeat (3) @(negedge clk);
      #1;
      check("R1", "data_out in reset", dout, 0);
      check("R1", "early_sel_err in reset", eflag, 0);
      check("R1", "short_hold_err in reset", hflag, 0);
      rst_n = 1;
      model_reset();
   endtask

   task automatic quiet(input int n, input int s, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, s, 1'b0, tag);
   endtask

   // R2: single pulse probe at code s
   task automatic pulse_probe(input int s, input int cur);
      int d;
      d = BASE + s * STEP;
      quiet(DEPTH + 2, cur, "R2");
      step(1'b1, s, 1'b0, "R2");
      for (int j = 1; j <= DEPTH + 2; j++) begin
         step(1'b0, s, 1'b0, "R2");
         probe[j] = obs;
      end
      check("R2", "pulse at tap", probe[d], 1);
      check("R2", "one cycle before tap", probe[d-1], 0);
      check("R2", "one cycle after tap", probe[d+1], 0);
   endtask

   initial begin
      @(negedge clk);
      do_reset();

      // R1: cleared chain while ones stream in
      for (int i = 0; i < BASE; i++) step(1'b1, 0, 1'b0, "R1");

      // R2: delay per code, raising only after long quiet
      pulse_probe(0, 0);
      pulse_probe(3, 0);
      pulse_probe(7, 3);
      check("R10", "no flag after slow raises", eflag, 0);

      // R3 / R6: lowering codes mid-stream moves the tap at once, no flag
      for (int c = 7; c >= 0; c -= 2) begin
         for (int i = 0; i < 10; i++) step(1'($urandom_range(0, 1)), c, 1'b0, "R3");
      end
      step(1'b0, 0, 1'b0, "R6");
      check("R6", "lowering never flags", eflag, 0);

      // R4 / R8: force at code 0, data keeps shifting, no hold needed
      step(1'b1, 0, 1'b1, "R4");
      step(1'b0, 0, 1'b1, "R4");
      step(1'b1, 0, 1'b1, "R4");
      step(1'b1, 0, 1'b1, "R4");
      step(1'b0, 0, 1'b0, "R4");
      check("R4", "forced bit shows after release", obs, 1);
      step(1'b0, 0, 1'b0, "R4");
      check("R4", "second forced bit after release", obs, 1);
      check("R8", "zero code needs no hold", hflag, 0);

      // R8: hold restarted by a high input, exact boundary at code 2
      quiet(DEPTH + 2, 0, "R8");
      quiet(4, 2, "R8");
      for (int i = 0; i < 4; i++) step(1'b0, 2, 1'b1, "R8");
      step(1'b1, 2, 1'b1, "R8");
      for (int i = 0; i < 6; i++) step(1'b0, 2, 1'b1, "R8");
      step(1'b0, 2, 1'b0, "R8");
      step(1'b0, 2, 1'b0, "R8");
      check("R8", "exact hold legal", hflag, 0);

      // R7: one cycle short
      quiet(4, 2, "R7");
      for (int i = 0; i < 5; i++) step(1'b0, 2, 1'b1, "R7");
      step(1'b0, 2, 1'b0, "R7");
      check("R7", "short hold flagged", hflag, 1);

      // R9: sticky, data unaffected
      for (int i = 0; i < 20; i++) step(1'($urandom_range(0, 1)), 2, 1'b0, "R9");
      check("R9", "hold flag stays set", hflag, 1);
      do_reset();

      // R5: exact quiet window then an early raise
      step(1'b1, 0, 1'b0, "R5");
      quiet(6, 0, "R5");
      step(1'b0, 1, 1'b0, "R5");
      step(1'b0, 1, 1'b0, "R5");
      check("R5", "exact wait legal", eflag, 0);
      quiet(DEPTH + 2, 1, "R5");
      step(1'b1, 1, 1'b0, "R5");
      quiet(6, 1, "R5");
      step(1'b0, 3, 1'b0, "R5");
      step(1'b0, 3, 1'b0, "R5");
      check("R5", "early raise flagged", eflag, 1);
      check("R9", "data path unaffected by flag", obs, model_out(3, 1'b0));

      // R10: first change after reset is never early
      sel = 7;
      do_reset();
      step(1'b1, 7, 1'b0, "R10");
      step(1'b0, 7, 1'b0, "R10");
      check("R10", "first change after reset", eflag, 0);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int s;
         bit f;
         s = (i % 40 < 30) ? ((i / 40) % 8) : 0;
         f = (i % 97) > 85;
         step(1'($urandom_range(0, 1)), s, f, "R2");
      end

      finish_run();
   end
endmodule